// File: doc/BRIEF.md
# Cascadable Presettable Binary Up-Counter

This block is a synchronous binary up-counter built from identical 4-bit cells. Every cell has a parallel preset, a synchronous active-low clear, and a carry output. A parameter sets how many cells are chained. Each cell's carry feeds the carry-gating enable of the cell above it, so the chain behaves as one wide counter with a single shared clock.

Two enables control counting, and a step happens only when both are high. The first enable is shared by every cell. The second enable gates the carry chain, so it also gates the chain's terminal-count output without waiting for a clock edge.

Clear takes priority over preset, and preset takes priority over counting. All of these controls act only at a rising clock edge.

Top module: `tally_chain`

## Requirements
- R1: When `clr_n` is 0 at a rising edge of `clk`, every bit of `q` is 0 after that edge, whatever the other inputs are.
- R2: When `clr_n` is 1 and `ld_n` is 0 at a rising edge, `q` takes the value of `din` after that edge, whatever the two enables are.
- R3: When `clr_n` and `ld_n` are both 1 and both `cnt_en` and `carry_en` are 1 at a rising edge, `q` increases by one, modulo 2^(4*STAGES).
- R4: When `clr_n` and `ld_n` are both 1 and either `cnt_en` or `carry_en` is 0 at a rising edge, `q` keeps its value.
- R5: `tc_out` is 1 exactly when `carry_en` is 1 and every bit of `q` is 1. It is combinational: it follows `carry_en` between clock edges, and `cnt_en` has no effect on it.
- R6: A counting edge with `q` at all ones makes `q` all zeros.
- R7: `q` is made of STAGES 4-bit cells, with cell 0 in bits [3:0]. During counting, cell k (k > 0) changes only on an edge where every bit of `q` below it is 1.
- R8: When `clr_n` and `ld_n` are both 0 at the same edge, the clear wins and `q` becomes 0.
- R9: With STAGES = 2, the following sequence runs as described. A clear gives 0x00. A preset of 0x0C is followed by six counting edges, which give 0x0D, 0x0E, 0x0F, 0x10, 0x11 and 0x12. After that, edges with both enables at 0 hold 0x12.
- R10: A low pulse on `clr_n` or `ld_n` that begins and ends between two rising edges has no effect on `q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| ld_n | input | 1 | Synchronous parallel preset, active low |
| cnt_en | input | 1 | Count enable shared by all cells |
| carry_en | input | 1 | Count enable that also gates the carry chain and `tc_out` |
| din | input | 4*STAGES | Parallel preset value |
| q | output | 4*STAGES | Counter value, cell 0 in the low bits |
| tc_out | output | 1 | Terminal-count carry of the last cell |

## Verification
From the ports, the hardest condition to reach is an upper cell stepping exactly when the cells below it are all ones. A plain count from zero gets there only after 2^(4k) edges. The stimulus instead presets values just below each cell boundary (0x0F, 0xFE, 0xFF) and then counts across the boundary. Every value is also preset once, each with a different enable combination. This confirms that the enables never block a preset and that `tc_out` goes high only when `carry_en` is 1 and the whole word is all ones. The stimulus also drops `clr_n` and `ld_n` for less than a clock period between edges, to show that only the sampled level matters.

// File: rtl/tally_pkg.sv
package tally_pkg;

  localparam int CELL_W = 4;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cell_op_e;

  // Priority: clear, then preset, then count (both enables), else hold.
  function automatic cell_op_e pick_op(input logic clr_n, input logic ld_n,
                                       input logic en_a, input logic en_b);
    if (!clr_n)            return OP_CLEAR;
    else if (!ld_n)        return OP_LOAD;
    else if (en_a && en_b) return OP_COUNT;
    else                   return OP_HOLD;
  endfunction

  function automatic logic [CELL_W-1:0] next_value(input logic [CELL_W-1:0] cur,
                                                   input cell_op_e op,
                                                   input logic [CELL_W-1:0] preset);
    unique case (op)
      OP_CLEAR: return '0;
      OP_LOAD:  return preset;
      OP_COUNT: return cur + CELL_W'(1);
      default:  return cur;
    endcase
  endfunction

  function automatic logic is_full(input logic [CELL_W-1:0] cur);
    return &cur;
  endfunction

endpackage

// File: rtl/tally_op_decode.sv
module tally_op_decode
  import tally_pkg::*;
(
  input  logic     clr_n,
  input  logic     ld_n,
  input  logic     cnt_en,
  input  logic     carry_in,
  output cell_op_e op
);

  always_comb begin
    op = pick_op(clr_n, ld_n, cnt_en, carry_in);
  end

endmodule

// File: rtl/tally_cell.sv
module tally_cell
  import tally_pkg::*;
(
  input  logic              clk,
  input  logic              clr_n,
  input  logic              ld_n,
  input  logic              cnt_en,
  input  logic              carry_in,
  input  logic [CELL_W-1:0] d,
  output logic [CELL_W-1:0] q,
  output logic              carry_out
);

  cell_op_e          op;
  logic              full_w;
  logic              step_w;
  logic [CELL_W-1:0] q_next;

  tally_op_decode u_dec (
    .clr_n    (clr_n),
    .ld_n     (ld_n),
    .cnt_en   (cnt_en),
    .carry_in (carry_in),
    .op       (op)
  );

  assign full_w    = is_full(q);
  assign step_w    = (op == OP_COUNT);
  assign q_next    = next_value(q, op, d);
  assign carry_out = carry_in & full_w;

  always_ff @(posedge clk) begin
    q <= q_next;
  end

  assert_clear_R1: assert property (@(posedge clk)
    !clr_n |=> (q == '0));

  assert_clear_beats_load_R8: assert property (@(posedge clk)
    (!clr_n && !ld_n) |=> (q == '0));

  assert_preset_R2: assert property (@(posedge clk) disable iff (!clr_n)
    !ld_n |=> (q == $past(d)));

  assert_step_R3: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && cnt_en && carry_in) |=> (q == CELL_W'($past(q) + CELL_W'(1))));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && !(cnt_en && carry_in)) |=> $stable(q));

  assert_wrap_R6: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && cnt_en && carry_in && (&q)) |=> (q == '0));

endmodule

// File: rtl/tally_chain.sv
module tally_chain
  import tally_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic                       clk,
  input  logic                       clr_n,
  input  logic                       ld_n,
  input  logic                       cnt_en,
  input  logic                       carry_en,
  input  logic [STAGES*CELL_W-1:0]   din,
  output logic [STAGES*CELL_W-1:0]   q,
  output logic                       tc_out
);

  localparam int W = STAGES * CELL_W;

  logic [STAGES:0] cy;

  assign cy[0] = carry_en;

  for (genvar i = 0; i < STAGES; i++) begin : g_cell
    tally_cell u_cell (
      .clk       (clk),
      .clr_n     (clr_n),
      .ld_n      (ld_n),
      .cnt_en    (cnt_en),
      .carry_in  (cy[i]),
      .d         (din[i*CELL_W +: CELL_W]),
      .q         (q[i*CELL_W +: CELL_W]),
      .carry_out (cy[i+1])
    );

    if (i > 0) begin : g_upper_chk
      assert_upper_waits_R7: assert property (@(posedge clk) disable iff (!clr_n)
        (ld_n && !(cnt_en && carry_en && (&q[i*CELL_W-1:0])))
          |=> $stable(q[i*CELL_W +: CELL_W]));
    end
  end

  assign tc_out = cy[STAGES];

  assert_carry_R5: assert property (@(posedge clk)
    tc_out |-> (carry_en && (q == {W{1'b1}})));

  assert_carry_live_R5: assert property (@(posedge clk)
    (carry_en && (q == {W{1'b1}})) |-> tc_out);

endmodule

// File: tb/tally_chain_test.sv
`timescale 1ns/1ps
module tally_chain_test;

  localparam int STAGES = 2;
  localparam int W      = STAGES * 4;

  typedef struct {
    logic [W-1:0] exp_q;
    string        req;
  } sb_item_t;

  logic         clk = 1'b0;
  logic         clr_n = 1'b0;
  logic         ld_n = 1'b1;
  logic         cnt_en = 1'b0;
  logic         carry_en = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] q;
  logic         tc_out;

  logic [W-1:0] model_q = '0;
  sb_item_t     sb[$];
  int           checks = 0;
  int           fails = 0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  tally_chain #(.STAGES(STAGES)) uut (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .cnt_en(cnt_en),
    .carry_en(carry_en), .din(din), .q(q), .tc_out(tc_out)
  );

  function automatic logic [W-1:0] ref_next(logic [W-1:0] cur, logic c, logic l,
                                            logic p, logic t, logic [W-1:0] d);
    if (c == 1'b0) return '0;
    if (l == 1'b0) return d;
    if (p && t)    return cur + 1'b1;
    return cur;
  endfunction

  task automatic expect_tc(string req);
    logic want;
    want = carry_en && (model_q == {W{1'b1}});
    checks++;
    if (tc_out !== want) begin
      fails++;
      $display("FAIL %s tc_out actual=%0b expected=%0b (q=%h)", req, tc_out, want, model_q);
    end
  endtask

  task automatic step(logic c, logic l, logic p, logic t, logic [W-1:0] d, string req);
    sb_item_t it;
    @(negedge clk);
    clr_n = c; ld_n = l; cnt_en = p; carry_en = t; din = d;
    #1;
    expect_tc("R5");
    model_q = ref_next(model_q, c, l, p, t, d);
    it.exp_q = model_q;
    it.req   = req;
    sb.push_back(it);
  endtask

  task automatic pulse_step(bit on_clear, string req);
    sb_item_t it;
    @(negedge clk);
    clr_n = 1'b1; ld_n = 1'b1; cnt_en = 1'b0; carry_en = 1'b0; din = ~model_q;
    if (on_clear) clr_n = 1'b0; else ld_n = 1'b0;
    #1;
    clr_n = 1'b1; ld_n = 1'b1;
    it.exp_q = model_q;
    it.req   = req;
    sb.push_back(it);
  endtask

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      sb_item_t it;
      it = sb.pop_front();
      checks++;
      if (q !== it.exp_q) begin
        fails++;
        $display("FAIL %s q actual=%h expected=%h", it.req, q, it.exp_q);
      end
    end
  end

  initial begin
    #500000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] seq [7];
    // Reset state (R1) and clear priority over load (R8)
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'h33, "R1");
    step(1'b0, 1'b1, 1'b0, 1'b0, 8'hA5, "R1");
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h77, "R2");
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'h5A, "R8");

    // Reference sequence R9
    step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R9");
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h0C, "R9");
    for (int k = 0; k < 6; k++) step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R9");
    for (int k = 0; k < 2; k++) step(1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, "R9");

    // Preset every value with rotating enables (R2)
    for (int v = 0; v < (1 << W); v++)
      step(1'b1, 1'b0, v[0], v[1], W'(v), "R2");

    // Hold with one enable low (R4)
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h3C, "R2");
    step(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R4");
    step(1'b1, 1'b1, 1'b0, 1'b1, 8'h00, "R4");
    step(1'b1, 1'b1, 1'b0, 1'b0, 8'h00, "R4");

    // Cell boundary crossing (R7) and word wrap (R6), carry gating (R5)
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h0F, "R7");
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R7");
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R3");
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'hFE, "R6");
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R3");
    step(1'b1, 1'b1, 1'b0, 1'b1, 8'h00, "R5");
    step(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R5");
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R6");
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R6");

    // Between-edge pulses (R10)
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h9B, "R2");
    pulse_step(1'b1, "R10");
    pulse_step(1'b0, "R10");

    // Long count run through several carries (R3, R7)
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'hE0, "R2");
    for (int k = 0; k < 300; k++) step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R3");

    // Mixed pattern
    for (int k = 0; k < 400; k++) begin
      logic [3:0] r;
      r = 4'(k * 7 + (k >> 3));
      step(r != 4'd0, r[3:1] != 3'd5, r[0] | r[2], r[1] | r[3], W'(k * 37), "R3");
    end

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule